// File: doc/BRIEF.md
# Bit-Banged Serial Real-Time-Clock Slave

This block is the device side of a three-wire serial clock chip that software drives by toggling bits in a system control register. The three bits are a select, a serial clock and a data bit. While select is high, each falling edge of the serial clock moves the transaction on by one phase. The first eight phases shift in a command byte, most significant bit first. The next eight phases shift in a value byte in the same order and, for read commands, return a byte on the output data line.

The command byte picks the action. One range reads a 32-byte battery-backed RAM and a second range writes it. Two codes read status bytes. A group of codes reads calendar and time fields as packed BCD. One code writes a control byte, and one bit of that byte clears two status flags and sends a one-cycle pulse to the interrupt controller. The time counters are outside the block and feed it binary values. The RAM powers up from an image given as a parameter.

All three serial inputs are taken to be synchronous to `clk_i`. The serial clock must stay at each level for at least one `clk_i` cycle.

Top module: `srtc_slave`

## Requirements
- R1: While reset is asserted and after it is released, `sdata_o` and `flag_clr_o` are 0. The status byte read by command 0x30 is 0x90. RAM byte i holds the parameter image, whose default is (29*i + 7) mod 256.
- R2: A phase advances only on a `clk_i` edge where `sel_i` is 1, the `sclk_i` value from the previous edge was 1, and `sclk_i` is now 0. Serial-clock toggles while `sel_i` is 0 have no effect on the next transaction. Rising edges and steady levels have no effect either.
- R3: When `sel_i` is sampled 0, the phase, the command and the value are cleared and `sdata_o` is 0 from the next cycle on. A write that is dropped before its 16th falling edge leaves the RAM unchanged.
- R4: Commands 0x00 to 0x1F return RAM byte `cmd`, MSB first. The falling edge of phase 8+k puts bit 7-k on `sdata_o` in the following cycle, and `sdata_o` holds that bit until the next falling edge.
- R5: Commands 0x80 to 0x9F store the 8-bit value at RAM address `cmd`-0x80 when the 16th falling edge arrives. The new byte is then returned by a later read.
- R6: Command 0x30 returns the status byte. Command 0x31 returns 0x00.
- R7: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day, month and year in packed BCD, with the tens digit in bits 7:4 and the ones digit in bits 3:0. The binary inputs range from 0 to 99. Commands 0x23 and 0x27 to 0x2F return 0x00.
- R8: Command 0xB1 with value bit 2 set clears status bits 4 and 3. In that case `flag_clr_o` is 1 for exactly one cycle, the cycle after the 16th falling edge. With bit 2 clear, the status byte and `flag_clr_o` do not change.
- R9: Commands outside the read ranges, write commands included, keep `sdata_o` at 0 during the second byte. Falling edges after the 16th in the same transaction change neither the RAM nor `sdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Transaction select from the control register |
| sclk_i | input | 1 | Serial clock bit from the control register |
| sdata_i | input | 1 | Serial data bit written by software |
| tm_sec_i | input | 7 | Seconds, binary |
| tm_min_i | input | 7 | Minutes, binary |
| tm_hour_i | input | 7 | Hours, binary |
| tm_day_i | input | 7 | Day of month, binary |
| tm_mon_i | input | 7 | Month, binary |
| tm_year_i | input | 7 | Two-digit year, binary |
| sdata_o | output | 1 | Serial read data returned to the control register |
| flag_clr_o | output | 1 | One-cycle pulse to the interrupt controller when the flag is cleared |

## Verification
Every result is registered once after the `clk_i` edge that sees the serial falling edge. A read bit, a RAM or status update and the flag pulse all become visible in the cycle after that edge. The bench changes its inputs on the falling edge of `clk_i`. It drops the serial clock, waits one full `clk_i` period so that exactly one rising edge does the detection, and then samples the outputs. This places the 16th-phase sample of `flag_clr_o` inside its single high cycle, and the sample after release catches the pulse ending. Clearing on select loss is checked one `clk_i` period after `sel_i` falls.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
  localparam int BYTE_W    = 8;
  localparam int RAM_WORDS = 32;
  localparam int ADDR_W    = $clog2(RAM_WORDS);
  localparam int TM_W      = 7;
  localparam int TM_FIELDS = 6;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_RAM_RD, ACT_RAM_WR, ACT_STAT0, ACT_STAT1, ACT_TIME, ACT_CTRL
  } act_e;

  function automatic act_e decode_cmd(input logic [BYTE_W-1:0] cmd);
    if (cmd <= 8'h1F) return ACT_RAM_RD;
    if (cmd >= 8'h20 && cmd <= 8'h2F) return ACT_TIME;
    if (cmd == 8'h30) return ACT_STAT0;
    if (cmd == 8'h31) return ACT_STAT1;
    if (cmd >= 8'h80 && cmd <= 8'h9F) return ACT_RAM_WR;
    if (cmd == 8'hB1) return ACT_CTRL;
    return ACT_NONE;
  endfunction

  function automatic logic [RAM_WORDS*BYTE_W-1:0] default_image();
    logic [RAM_WORDS*BYTE_W-1:0] img;
    for (int i = 0; i < RAM_WORDS; i++) img[i*BYTE_W +: BYTE_W] = BYTE_W'(i * 29 + 7);
    return img;
  endfunction
endpackage

// File: rtl/srtc_shifter.sv
module srtc_shifter #(
  parameter int BYTE_W  = 8,
  localparam int PHASES = 2 * BYTE_W,
  localparam int PH_W   = $clog2(PHASES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              bit_stb_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] val_full_o
);
  logic              sclk_q;
  logic [PH_W-1:0]   phase_q;
  logic [BYTE_W-1:0] cmd_q;
  logic [BYTE_W-2:0] val_q;  // last value bit is taken straight from sdata_i

  assign bit_stb_o  = sel_i && sclk_q && !sclk_i && (phase_q < PH_W'(PHASES));
  assign phase_o    = phase_q;
  assign cmd_o      = cmd_q;
  assign val_full_o = {val_q, sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      phase_q <= '0;
      cmd_q   <= '0;
      val_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (!sel_i) begin
        phase_q <= '0;
        cmd_q   <= '0;
        val_q   <= '0;
      end else if (bit_stb_o) begin
        phase_q <= phase_q + 1'b1;
        if (phase_q < PH_W'(BYTE_W)) cmd_q <= {cmd_q[BYTE_W-2:0], sdata_i};
        else                         val_q <= {val_q[BYTE_W-3:0], sdata_i};
      end
    end
  end
endmodule

// File: rtl/srtc_store.sv
module srtc_store #(
  parameter int BYTE_W    = 8,
  parameter int RAM_WORDS = 32,
  parameter logic [RAM_WORDS*BYTE_W-1:0] RAM_INIT = '0,
  parameter logic [BYTE_W-1:0] STATUS_RST = 8'h90,
  parameter logic [BYTE_W-1:0] CLR_MASK   = 8'h18,
  localparam int ADDR_W = $clog2(RAM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              clr_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] status_o
);
  logic [BYTE_W-1:0] mem_q [RAM_WORDS];
  logic [BYTE_W-1:0] status_q;

  for (genvar w = 0; w < RAM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[w] <= RAM_INIT[w*BYTE_W +: BYTE_W];
      else if (wr_en_i && wr_addr_i == ADDR_W'(w))     mem_q[w] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       status_q <= STATUS_RST;
    else if (clr_en_i) status_q <= status_q & ~CLR_MASK;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign status_o  = status_q;
endmodule

// File: rtl/srtc_bcd.sv
module srtc_bcd #(
  parameter int IN_W = 7
) (
  input  logic [IN_W-1:0] bin_i,
  output logic [7:0]      bcd_o
);
  logic [3:0] tens, ones;
  assign tens  = 4'(bin_i / IN_W'(10));
  assign ones  = 4'(bin_i % IN_W'(10));
  assign bcd_o = {tens, ones};
endmodule

// File: rtl/srtc_slave.sv
module srtc_slave
  import srtc_pkg::*;
#(
  parameter logic [RAM_WORDS*BYTE_W-1:0] RAM_INIT = default_image(),
  parameter logic [BYTE_W-1:0] STATUS_RST = 8'h90,
  localparam int PH_W = $clog2(2 * BYTE_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            sclk_i,
  input  logic            sdata_i,
  input  logic [TM_W-1:0] tm_sec_i,
  input  logic [TM_W-1:0] tm_min_i,
  input  logic [TM_W-1:0] tm_hour_i,
  input  logic [TM_W-1:0] tm_day_i,
  input  logic [TM_W-1:0] tm_mon_i,
  input  logic [TM_W-1:0] tm_year_i,
  output logic            sdata_o,
  output logic            flag_clr_o
);
  logic              bit_stb;
  logic [PH_W-1:0]   phase;
  logic [BYTE_W-1:0] cmd, val_full, ram_rd, status;
  logic              last_bit, wr_en, clr_en;
  act_e              act;

  srtc_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .sel_i, .sclk_i, .sdata_i,
    .bit_stb_o(bit_stb), .phase_o(phase), .cmd_o(cmd), .val_full_o(val_full)
  );

  assign act      = decode_cmd(cmd);
  assign last_bit = bit_stb && (phase == PH_W'(2 * BYTE_W - 1));
  assign wr_en    = last_bit && (act == ACT_RAM_WR);
  assign clr_en   = last_bit && (act == ACT_CTRL) && val_full[2];

  srtc_store #(
    .BYTE_W(BYTE_W), .RAM_WORDS(RAM_WORDS), .RAM_INIT(RAM_INIT), .STATUS_RST(STATUS_RST)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(cmd[ADDR_W-1:0]), .wr_data_i(val_full),
    .clr_en_i(clr_en), .rd_addr_i(cmd[ADDR_W-1:0]),
    .rd_data_o(ram_rd), .status_o(status)
  );

  logic [TM_W-1:0] tm_bin [TM_FIELDS];
  logic [7:0]      tm_bcd [TM_FIELDS];
  assign tm_bin[0] = tm_sec_i;
  assign tm_bin[1] = tm_min_i;
  assign tm_bin[2] = tm_hour_i;
  assign tm_bin[3] = tm_day_i;
  assign tm_bin[4] = tm_mon_i;
  assign tm_bin[5] = tm_year_i;

  for (genvar f = 0; f < TM_FIELDS; f++) begin : g_bcd
    srtc_bcd #(.IN_W(TM_W)) u_bcd (.bin_i(tm_bin[f]), .bcd_o(tm_bcd[f]));
  end

  // low nibble 3 is a hole in the time map
  logic [7:0] time_byte;
  always_comb begin
    unique case (cmd[3:0])
      4'h0:    time_byte = tm_bcd[0];
      4'h1:    time_byte = tm_bcd[1];
      4'h2:    time_byte = tm_bcd[2];
      4'h4:    time_byte = tm_bcd[3];
      4'h5:    time_byte = tm_bcd[4];
      4'h6:    time_byte = tm_bcd[5];
      default: time_byte = 8'h00;
    endcase
  end

  logic [BYTE_W-1:0] rd_byte;
  always_comb begin
    unique case (act)
      ACT_RAM_RD: rd_byte = ram_rd;
      ACT_STAT0:  rd_byte = status;
      ACT_TIME:   rd_byte = time_byte;
      default:    rd_byte = '0;
    endcase
  end

  logic sdata_q, flag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdata_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      flag_q <= clr_en;
      if (!sel_i)
        sdata_q <= 1'b0;
      else if (bit_stb && phase >= PH_W'(BYTE_W))
        sdata_q <= rd_byte[~phase[2:0]];  // bit 15-phase
    end
  end

  assign sdata_o    = sdata_q;
  assign flag_clr_o = flag_q;
endmodule

// File: rtl/srtc_slave_chk.sv
module srtc_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_i,
  input logic sclk_i,
  input logic sdata_o,
  input logic flag_clr_o
);
  AST_FLAG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_o |=> !flag_clr_o);  // R8
  AST_FLAG_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_o |-> $past(sel_i));  // R8
  AST_FLAG_ON_LOW_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_o |-> !$past(sclk_i));  // R2
  AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !sdata_o);  // R3
  AST_HIGH_SCLK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && sclk_i) |=> $stable(sdata_o));  // R2
endmodule

bind srtc_slave srtc_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .sclk_i(sclk_i),
  .sdata_o(sdata_o), .flag_clr_o(flag_clr_o)
);

// File: tb/srtc_slave_test.sv
module srtc_slave_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0;
  logic [6:0] tm [6];
  logic sdata_o, flag_clr_o;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [7:0] ram_m [32];
  logic [7:0] stat_m;

  always #4 clk = ~clk;

  srtc_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .sclk_i(sclk), .sdata_i(sdin),
    .tm_sec_i(tm[0]), .tm_min_i(tm[1]), .tm_hour_i(tm[2]),
    .tm_day_i(tm[3]), .tm_mon_i(tm[4]), .tm_year_i(tm[5]),
    .sdata_o(sdata_o), .flag_clr_o(flag_clr_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] c);
    if (c <= 8'h1F) return ram_m[c[4:0]];
    if (c == 8'h30) return stat_m;
    case (c)
      8'h20: return to_bcd(int'(tm[0]));
      8'h21: return to_bcd(int'(tm[1]));
      8'h22: return to_bcd(int'(tm[2]));
      8'h24: return to_bcd(int'(tm[3]));
      8'h25: return to_bcd(int'(tm[4]));
      8'h26: return to_bcd(int'(tm[5]));
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_commit(input logic [7:0] c, input logic [7:0] v);
    if (c >= 8'h80 && c <= 8'h9F) ram_m[c[4:0]] = v;
    if (c == 8'hB1 && v[2]) stat_m = stat_m & ~8'h18;
  endtask

  // inputs change at negedge; each low sclk spans exactly one detecting posedge before sampling
  task automatic xfer(input logic [7:0] c, input logic [7:0] v, input int nbits,
                      output logic [7:0] rd, output logic flag, output logic extra_or);
    rd = 8'h00; flag = 1'b0; extra_or = 1'b0;
    sel = 1'b1;
    @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      sdin = (i < 8) ? c[7-i] : (i < 16) ? v[15-i] : ~v[i%8];
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
      if (i >= 8 && i < 16) rd[15-i] = sdata_o;
      if (i == 15) flag = flag_clr_o;
      if (i >= 16) extra_or = extra_or | sdata_o | flag_clr_o;
    end
  endtask

  task automatic release_sel();
    sel = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic full(input logic [7:0] c, input logic [7:0] v, input string req,
                      input bit check_rd);
    logic [7:0] rd, expv; logic fl, ex;
    expv = exp_read(c);
    xfer(c, v, 16, rd, fl, ex);
    if (check_rd) chk(req, rd, expv);
    release_sel();
    model_commit(c, v);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd; logic fl, ex;
    void'($urandom(32'd5151));
    for (int i = 0; i < 32; i++) ram_m[i] = 8'(i * 29 + 7);
    stat_m = 8'h90;
    tm[0] = 7'd59; tm[1] = 7'd7; tm[2] = 7'd23; tm[3] = 7'd31; tm[4] = 7'd12; tm[5] = 7'd99;

    repeat (3) @(negedge clk);
    chk("R1 sdata_o in reset", {7'b0, sdata_o}, 8'h00);
    chk("R1 flag in reset", {7'b0, flag_clr_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 sdata_o after reset", {7'b0, sdata_o}, 8'h00);
    full(8'h30, 8'h00, "R1 status reset 0x90", 1);
    full(8'h00, 8'h00, "R1 ram[0] image", 1);
    full(8'h1F, 8'h00, "R1 ram[31] image", 1);

    // R4 bit timing: first bit appears one cycle after the phase-8 fall
    xfer(8'h05, 8'h00, 9, rd, fl, ex);
    chk("R4 first read bit", {7'b0, sdata_o}, {7'b0, ram_m[5][7]});
    // R3 abort clears output next cycle
    sel = 1'b0;
    @(negedge clk);
    chk("R3 sdata_o cleared on deselect", {7'b0, sdata_o}, 8'h00);
    @(negedge clk);

    // R3 aborted write leaves RAM untouched
    xfer(8'h85, 8'hA5, 14, rd, fl, ex);
    release_sel();
    full(8'h05, 8'h00, "R3 aborted write ignored", 1);

    // R2 toggles with sel low do nothing
    for (int i = 0; i < 6; i++) begin
      sclk = 1'b1; sdin = 1'b1; @(negedge clk);
      sclk = 1'b0; @(negedge clk);
    end
    full(8'h02, 8'h00, "R2 deselected toggles ignored", 1);

    // R5 write then read
    full(8'h83, 8'h3C, "R5", 0);
    full(8'h03, 8'h00, "R5 written byte readback", 1);
    full(8'h9F, 8'hC1, "R5", 0);
    full(8'h1F, 8'h00, "R5 top address readback", 1);

    // R6
    full(8'h31, 8'h00, "R6 status1 zero", 1);

    // R7 time fields and holes
    full(8'h20, 8'h00, "R7 seconds", 1);
    full(8'h21, 8'h00, "R7 minutes", 1);
    full(8'h22, 8'h00, "R7 hours", 1);
    full(8'h24, 8'h00, "R7 day", 1);
    full(8'h25, 8'h00, "R7 month", 1);
    full(8'h26, 8'h00, "R7 year", 1);
    full(8'h23, 8'h00, "R7 hole 0x23", 1);
    full(8'h2F, 8'h00, "R7 hole 0x2F", 1);

    // R8 control without bit 2
    xfer(8'hB1, 8'hFB, 16, rd, fl, ex);
    chk("R8 no pulse without bit2", {7'b0, fl}, 8'h00);
    release_sel();
    full(8'h30, 8'h00, "R8 status kept", 1);
    // R8 control with bit 2
    xfer(8'hB1, 8'h04, 16, rd, fl, ex);
    chk("R8 pulse high", {7'b0, fl}, 8'h01);
    @(negedge clk);
    chk("R8 pulse one cycle", {7'b0, flag_clr_o}, 8'h00);
    release_sel();
    model_commit(8'hB1, 8'h04);
    full(8'h30, 8'h00, "R8 status cleared to 0x80", 1);
    chk("R8 model status", stat_m, 8'h80);

    // R9 write command returns no data; extra edges ignored
    xfer(8'h88, 8'h5A, 20, rd, fl, ex);
    chk("R9 write cmd data line", rd, 8'h00);
    chk("R9 extra edges quiet", {7'b0, ex}, 8'h00);
    release_sel();
    model_commit(8'h88, 8'h5A);
    full(8'h08, 8'h00, "R9 extra edges did not rewrite", 1);
    full(8'h55, 8'h00, "R9 unmapped cmd", 1);
    xfer(8'h07, 8'h00, 24, rd, fl, ex);
    chk("R4 read with extra edges", rd, ram_m[7]);
    release_sel();

    // random mix
    for (int n = 0; n < 80; n++) begin
      int op;
      logic [7:0] c, v;
      op = int'($urandom_range(0, 4));
      v  = 8'($urandom);
      case (op)
        0: c = 8'h80 | 8'($urandom_range(0, 31));
        1: c = 8'($urandom_range(0, 31));
        2: begin
          for (int f = 0; f < 6; f++) tm[f] = 7'($urandom_range(0, 99));
          c = 8'h20 | 8'($urandom_range(0, 15));
        end
        3: c = 8'h30 | 8'($urandom_range(0, 1));
        default: c = 8'($urandom);
      endcase
      if (c == 8'hB1) c = 8'h40;
      full(c, v, (op == 2) ? "R7 random time" : (op == 0) ? "R5 random write"
                 : "R4 random read", 1);
      if (op == 0) full({3'b000, c[4:0]}, 8'h00, "R5 random readback", 1);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule